// File: doc/BRIEF.md
# Three-Wire Codec Control Port

This block is the slave side of a serial control link that a microcontroller uses to configure an audio codec. The link has three lines: a phase line that tells an address phase (low) from a data phase (high), a serial clock, and one bidirectional data line. All three lines are oversampled in the system clock domain through a two-flop synchronizer. Bits are taken on the detected rising edge of the serial clock, most significant bit first.

An address byte carries a six-bit device code in its upper bits and a two-bit transfer type in its lower bits. When the code matches, the port becomes selected, and it stays selected with that transfer type for any number of following data bytes until the next complete address byte. Write-type data bytes come out on a parallel write bus with a one-cycle strobe. A read-type data phase makes the port drive the data line with a status byte, such as a held peak level, supplied by the surrounding logic. A pulse after each returned byte lets that logic clear its held value.

Top module: `ctl3w_port`

## Requirements
- R1: During and right after reset, `wr_stb`, `rd_taken` and `sdat_oe` are low and the port is deselected, so data bytes sent before any address byte produce no strobe.
- R2: A byte is eight bits taken on eight rising edges of the synchronized serial clock, MSB first. It is acted on only after its eighth bit.
- R3: A complete byte received while the phase line is low is an address byte. The port is selected when bits 7..2 equal the parameter `DEV_CODE` (default 6'b000101). Bits 1..0 then become the current transfer type.
- R4: A complete address byte whose bits 7..2 differ from `DEV_CODE` deselects the port. Later data bytes then give no `wr_stb` and no `rd_taken`, and `sdat_oe` stays low.
- R5: The selection and transfer type stay in force across any number of data bytes, and across phase changes that carry no complete address byte.
- R6: When selected with a type other than `RD_TYPE`, each complete data byte (phase line high) gives exactly one single-cycle `wr_stb`. In that cycle `wr_data` holds the byte and `wr_grp` holds the transfer type.
- R7: Every change of the synchronized phase line clears the bit count, so a partial byte is discarded and the next byte starts at its MSB.
- R8: When selected with type `RD_TYPE` (default 2'b01) and the phase line high, `sdat_oe` is high. `sdat_o` then presents `rd_value` MSB first, one bit per serial clock. The controller samples each bit at the rising edge, and the port moves to the next bit after that edge.
- R9: `rd_value` is captured when a read data phase begins and again at the end of each returned byte. A single-cycle `rd_taken` marks each completed read byte.
- R10: A read-type byte never raises `wr_stb`. `sdat_oe` is low whenever the phase line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_i | input | 1 | Phase line: low = address, high = data |
| sclk_i | input | 1 | Serial clock from the controller |
| sdat_i | input | 1 | Serial data from the controller |
| rd_value | input | 8 | Status byte returned in read transfers |
| sdat_o | output | 1 | Serial data driven toward the controller |
| sdat_oe | output | 1 | Output enable for the data line |
| wr_stb | output | 1 | One-cycle strobe for a received write byte |
| wr_grp | output | 2 | Transfer type of the strobed byte |
| wr_data | output | 8 | Received write byte |
| rd_taken | output | 1 | One-cycle pulse after a returned read byte |

## Verification
A table of address and data byte pairs is sent through the port. The pairs cover every write type with a matching device code, and codes that differ in a low bit or in the top bit. This separates correct code decoding from type decoding and from bit-order mistakes. Directed sequences then send several bytes after a single address, which shows that the selection persists. Cut-off bytes around phase changes show that the count is cleared instead of carried over. A read of two bytes, with the status value changed in the middle of the first byte, checks the bit order, the capture points and that no write strobe appears.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 6;
  localparam int TYPE_W = 2;

  typedef logic [TYPE_W-1:0] xfer_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // device code sits above the transfer type in an address byte
  function automatic logic code_hit(input byte_t b, input logic [CODE_W-1:0] code);
    return b[BYTE_W-1:TYPE_W] == code;
  endfunction

  function automatic xfer_t type_of(input byte_t b);
    return b[TYPE_W-1:0];
  endfunction

  function automatic byte_t shift_in(input byte_t b, input logic bit_i);
    return {b[BYTE_W-2:0], bit_i};
  endfunction
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int LINES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] d,
  output logic [LINES-1:0] q
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/ctl3w_shift.sv
module ctl3w_shift
  import ctl3w_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bit_rise,
  input  logic  phase_edge,
  input  logic  din,
  output logic  byte_done,
  output byte_t byte_val
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0] cnt;
  byte_t            sreg;

  assign byte_val  = shift_in(sreg, din);
  assign byte_done = bit_rise && !phase_edge && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sreg <= '0;
    end else if (phase_edge) begin
      cnt  <= '0;
    end else if (bit_rise) begin
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
      sreg <= byte_val;
    end
  end
endmodule

// File: rtl/ctl3w_sel.sv
module ctl3w_sel
  import ctl3w_pkg::*;
#(
  parameter logic [CODE_W-1:0] DEV_CODE = 6'b000101,
  parameter xfer_t             RD_TYPE  = 2'b01
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  phase_data,
  input  logic  phase_rise,
  input  logic  bit_rise,
  input  logic  byte_done,
  input  byte_t byte_val,
  input  byte_t rd_value,
  output logic  selected,
  output logic  wr_stb,
  output xfer_t wr_grp,
  output byte_t wr_data,
  output logic  rd_taken,
  output logic  sdat_o,
  output logic  sdat_oe
);
  xfer_t cur_type;
  byte_t rd_sh;
  logic  rd_mode;

  assign rd_mode = selected && (cur_type == RD_TYPE);
  assign sdat_oe = rd_mode && phase_data;
  assign sdat_o  = sdat_oe && rd_sh[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selected <= 1'b0;
      cur_type <= '0;
      wr_stb   <= 1'b0;
      wr_grp   <= '0;
      wr_data  <= '0;
      rd_taken <= 1'b0;
      rd_sh    <= '0;
    end else begin
      wr_stb   <= 1'b0;
      rd_taken <= 1'b0;
      if (phase_rise && rd_mode)
        rd_sh <= rd_value;
      else if (bit_rise && sdat_oe)
        rd_sh <= {rd_sh[BYTE_W-2:0], 1'b0};
      if (byte_done) begin
        if (!phase_data) begin
          selected <= code_hit(byte_val, DEV_CODE);
          cur_type <= type_of(byte_val);
        end else if (rd_mode) begin
          rd_taken <= 1'b1;
          rd_sh    <= rd_value;
        end else if (selected) begin
          wr_stb  <= 1'b1;
          wr_data <= byte_val;
          wr_grp  <= cur_type;
        end
      end
    end
  end
endmodule

// File: rtl/ctl3w_port.sv
module ctl3w_port
  import ctl3w_pkg::*;
#(
  parameter logic [CODE_W-1:0] DEV_CODE    = 6'b000101,
  parameter xfer_t             RD_TYPE     = 2'b01,
  parameter int                SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phase_i,
  input  logic       sclk_i,
  input  logic       sdat_i,
  input  logic [7:0] rd_value,
  output logic       sdat_o,
  output logic       sdat_oe,
  output logic       wr_stb,
  output logic [1:0] wr_grp,
  output logic [7:0] wr_data,
  output logic       rd_taken
);
  localparam int LINES = 3;

  logic [LINES-1:0] lvl;
  logic phase_data, sclk_s, sdat_s;
  logic phase_prev, sclk_prev;
  logic bit_rise, phase_edge, phase_rise;
  logic byte_done, selected;
  byte_t byte_val;

  ctl3w_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sdat_i, sclk_i, phase_i}), .q(lvl)
  );

  assign phase_data = lvl[0];
  assign sclk_s     = lvl[1];
  assign sdat_s     = lvl[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_prev <= 1'b0;
      sclk_prev  <= 1'b0;
    end else begin
      phase_prev <= phase_data;
      sclk_prev  <= sclk_s;
    end
  end

  assign bit_rise   = sclk_s && !sclk_prev;
  assign phase_edge = phase_data ^ phase_prev;
  assign phase_rise = phase_data && !phase_prev;

  ctl3w_shift u_shift (
    .clk(clk), .rst_n(rst_n),
    .bit_rise(bit_rise), .phase_edge(phase_edge), .din(sdat_s),
    .byte_done(byte_done), .byte_val(byte_val)
  );

  ctl3w_sel #(.DEV_CODE(DEV_CODE), .RD_TYPE(RD_TYPE)) u_sel (
    .clk(clk), .rst_n(rst_n),
    .phase_data(phase_data), .phase_rise(phase_rise), .bit_rise(bit_rise),
    .byte_done(byte_done), .byte_val(byte_val), .rd_value(rd_value),
    .selected(selected), .wr_stb(wr_stb), .wr_grp(wr_grp), .wr_data(wr_data),
    .rd_taken(rd_taken), .sdat_o(sdat_o), .sdat_oe(sdat_oe)
  );
endmodule

// File: rtl/ctl3w_checker.sv
module ctl3w_checker (
  input logic clk,
  input logic rst_n,
  input logic wr_stb,
  input logic rd_taken,
  input logic sdat_oe,
  input logic byte_done,
  input logic phase_data,
  input logic selected
);
  a_r6_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  a_r2_stb_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(byte_done));
  a_r4_stb_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(selected));
  a_r10_stb_in_data: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(phase_data));
  a_r9_taken_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_taken |-> $past(byte_done) && !wr_stb);
  a_r10_no_drive_addr: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_data |-> !sdat_oe);
  a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && sdat_oe));
endmodule

bind ctl3w_port ctl3w_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_taken(rd_taken),
  .sdat_oe(sdat_oe), .byte_done(byte_done), .phase_data(phase_data),
  .selected(selected)
);

// File: tb/test_ctl3w_port.sv
module test_ctl3w_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phase_i = 1'b0, sclk_i = 1'b0, sdat_i = 1'b0;
  logic [7:0] rd_value = 8'h00;
  logic sdat_o, sdat_oe, wr_stb, rd_taken;
  logic [1:0] wr_grp;
  logic [7:0] wr_data;

  int n_chk = 0, n_bad = 0, n_stb = 0, n_taken = 0;
  logic [7:0] last_data = 8'h00;
  logic [1:0] last_grp = 2'b00;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ctl3w_port i_ctl3w_port (
    .clk(clk), .rst_n(rst_n), .phase_i(phase_i), .sclk_i(sclk_i),
    .sdat_i(sdat_i), .rd_value(rd_value), .sdat_o(sdat_o), .sdat_oe(sdat_oe),
    .wr_stb(wr_stb), .wr_grp(wr_grp), .wr_data(wr_data), .rd_taken(rd_taken)
  );

  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      n_stb++;
      last_data = wr_data;
      last_grp  = wr_grp;
    end
    if (rst_n && rd_taken) n_taken++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_phase(input logic p);
    phase_i = p;
    wait_clk(6);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      sdat_i = b[i];
      wait_clk(4);
      sclk_i = 1'b1;
      wait_clk(4);
      sclk_i = 1'b0;
    end
    wait_clk(4);
  endtask

  task automatic read_byte(output logic [7:0] v, input bit swap, input logic [7:0] nv);
    for (int i = 7; i >= 0; i--) begin
      wait_clk(4);
      v[i] = sdat_o;
      if (swap && i == 4) rd_value = nv;
      sclk_i = 1'b1;
      wait_clk(4);
      sclk_i = 1'b0;
    end
    wait_clk(6);
  endtask

  // {address byte, data byte, strobe expected, expected group}
  localparam logic [18:0] VEC [6] = '{
    {8'b0001_0100, 8'hA5, 1'b1, 2'b00},
    {8'b0001_0110, 8'h3C, 1'b1, 2'b10},
    {8'b0001_0111, 8'h81, 1'b1, 2'b11},
    {8'b0001_1100, 8'hFF, 1'b0, 2'b00},
    {8'b1001_0100, 8'h12, 1'b0, 2'b00},
    {8'b0001_0100, 8'h00, 1'b1, 2'b00}
  };

  initial begin
    int s0, t0;
    logic [7:0] got;
    wait_clk(3);
    // R1: reset state, then a data byte before any address
    chk(!wr_stb && !sdat_oe && !rd_taken, "R1 reset outputs", {wr_stb, sdat_oe, rd_taken}, 0);
    rst_n = 1'b1;
    wait_clk(3);
    set_phase(1'b1);
    send_bits(8'h77, 8);
    chk(n_stb == 0 && !sdat_oe, "R1 deselected after reset", n_stb, 0);

    // table: R2 R3 R4 R6
    foreach (VEC[k]) begin
      s0 = n_stb;
      set_phase(1'b0);
      send_bits(VEC[k][18:11], 8);
      set_phase(1'b1);
      send_bits(VEC[k][10:3], 8);
      if (VEC[k][2]) begin
        chk(n_stb == s0 + 1, "R3 R6 strobe count", n_stb - s0, 1);
        chk(last_data == VEC[k][10:3], "R2 R6 byte value", last_data, VEC[k][10:3]);
        chk(last_grp == VEC[k][1:0], "R3 group", last_grp, VEC[k][1:0]);
      end else begin
        chk(n_stb == s0, "R4 no strobe when code differs", n_stb - s0, 0);
      end
    end

    // R5: several bytes under one address
    set_phase(1'b0);
    send_bits(8'b0001_0110, 8);
    set_phase(1'b1);
    s0 = n_stb;
    send_bits(8'h11, 8);
    send_bits(8'h22, 8);
    send_bits(8'h93, 8);
    chk(n_stb == s0 + 3, "R5 strobes for three bytes", n_stb - s0, 3);
    chk(last_data == 8'h93 && last_grp == 2'b10, "R5 last byte and group", {last_grp, last_data}, {2'b10, 8'h93});

    // R7: partial data byte dropped by phase change
    s0 = n_stb;
    send_bits(8'hF0, 5);
    set_phase(1'b0);
    chk(n_stb == s0, "R7 partial data gives no strobe", n_stb - s0, 0);
    // R7 R5: partial address dropped, selection kept
    send_bits(8'b1111_1111, 3);
    set_phase(1'b1);
    send_bits(8'h5E, 8);
    chk(n_stb == s0 + 1 && last_data == 8'h5E, "R7 byte aligned after phase change", last_data, 8'h5E);
    chk(last_grp == 2'b10, "R5 group kept over partial address", last_grp, 2'b10);

    // R8 R9 R10: read two bytes
    rd_value = 8'hC6;
    set_phase(1'b0);
    chk(!sdat_oe, "R10 no drive in address phase", sdat_oe, 0);
    send_bits(8'b0001_0101, 8);
    s0 = n_stb; t0 = n_taken;
    set_phase(1'b1);
    chk(sdat_oe == 1'b1, "R8 drive in read phase", sdat_oe, 1);
    read_byte(got, 1'b1, 8'h5B);
    chk(got == 8'hC6, "R8 first read byte", got, 8'hC6);
    chk(n_taken == t0 + 1, "R9 taken pulse", n_taken - t0, 1);
    read_byte(got, 1'b0, 8'h00);
    chk(got == 8'h5B, "R9 recapture at byte end", got, 8'h5B);
    chk(n_stb == s0, "R10 read gives no write strobe", n_stb - s0, 0);
    set_phase(1'b0);
    chk(!sdat_oe, "R10 release on phase low", sdat_oe, 0);

    // R4: wrong code with read type
    send_bits(8'b0011_0101, 8);
    set_phase(1'b1);
    t0 = n_taken;
    chk(!sdat_oe, "R4 no drive when code differs", sdat_oe, 0);
    send_bits(8'hAA, 8);
    chk(n_taken == t0 && !sdat_oe, "R4 no read after mismatch", n_taken - t0, 0);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule